// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Access Freeze

This block keeps the time and the date in packed BCD: seconds, minutes, hours, day of month, weekday, month with a century bit, and a two-digit year. A built-in prescaler divides a 64 Hz strobe down to the one-second tick. The prescaler can be held at zero by a stop input. On release, the first second elapses after half a prescaler period, so software can start the clock at a known instant.

A host interface that reads or writes several counters raises `freeze` for the length of its access, so that no carry can ripple through the chain in the middle of the access. A tick that lands inside the freeze is not lost. It is parked and applied in the first cycle after release. Only one tick can be parked, and any further ticks during the same freeze are dropped. A write port loads any counter directly. A write to the seconds counter also discards a parked tick, because setting the seconds restarts the current second. Bit 7 of the seconds register is a sticky voltage-low flag.

The tick gate is a three-state machine:
- `GT_LIVE`: running, nothing parked.
- `GT_HOLD`: blocked by a freeze or a write, nothing parked.
- `GT_OWED`: one tick parked.

Its transitions are:
- LIVE or HOLD → OWED when a tick arrives while blocked and the access is not a seconds write.
- LIVE or HOLD → HOLD when blocked with no tick, or when the tick is cancelled by a seconds write.
- HOLD → LIVE when unblocked.
- OWED → HOLD on a seconds write.
- OWED → OWED while still blocked. An extra tick in this state is dropped.
- OWED → LIVE on release, issuing the parked advance.

Top module: `rtc_calendar_core`

## Requirements
- R1: Each rising 64 Hz strobe (`hz64_stb` high for one clock) advances the prescaler. Once running, a one-second tick occurs once every 64 strobes.
- R2: While `presc_stop` is high, the prescaler stays at zero and no tick occurs. After it drops, the first tick comes on the 32nd strobe and each later tick 64 strobes after the previous one.
- R3: Seconds and minutes are BCD 00–59. A tick at 59 seconds wraps the seconds to 00 and adds one minute, and 59 minutes wrap to 00 with a carry into the hours.
- R4: Hours run 00–23. The wrap from 23:59:59 sets the hours to 00, advances the day, and advances the weekday (0–6, with 6 wrapping to 0).
- R5: The day of month runs from 01 up to the month's length: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. Past the last day it returns to 01 and the month advances.
- R6: February has 29 days when the BCD year is a multiple of 4, including year 00, and 28 days otherwise.
- R7: Months run 01–12 in bits 4:0 of the month register, and years run 00–99. When the year wraps from 99 to 00, bit 7 of the month register (century) inverts.
- R8: While `freeze` is high, no counter changes. The first tick during a freeze is parked and applied on the first clock edge after `freeze` falls, and later ticks in that freeze are lost.
- R9: A write (`wr_sel`: 0 sec, 1 min, 2 hour, 3 day, 4 weekday, 5 month, 6 year) loads the counter at the next edge and blocks advancing in that cycle, so a coinciding tick is parked and applied next. A seconds write discards any parked or coinciding tick.
- R10: Bit 7 of the seconds register is 1 after reset and is set whenever `vlow` is high. It stays set until a seconds write with bit 7 = 0 is made while `vlow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hz64_stb | input | 1 | One-cycle strobe per 64 Hz period |
| presc_stop | input | 1 | Holds the prescaler at zero |
| freeze | input | 1 | Access in progress; counters hold |
| vlow | input | 1 | Supply-low indication |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | 3 | Counter select for a write |
| wr_data | input | 8 | BCD write data |
| seconds_o | output | 8 | {voltage-low flag, BCD seconds} |
| minutes_o | output | 8 | BCD minutes |
| hours_o | output | 8 | BCD hours |
| days_o | output | 8 | BCD day of month |
| weekday_o | output | 8 | Weekday 0–6 |
| months_o | output | 8 | {century, 2'b0, BCD month} |
| years_o | output | 8 | BCD year |

## Verification
Timing through the block is as follows:
- A strobe is registered into the prescaler tick at one edge, and the counters move at the following edge, so a second's effect is visible two edges after its strobe.
- Writes and the voltage-low flag appear one edge after the input.
- A parked tick shows one edge after `freeze` falls.

The bench drives inputs on the falling edge. It samples parked-tick releases exactly one edge after release, to pin the latency, and samples everything else after three idle cycles. It times its directed write to land in the cycle in which the tick is registered, so that the deferral path of R9 is exercised.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned PRESC_DIV = 64;

    localparam logic [REG_W-1:0] SEC_MAX   = 8'd59;
    localparam logic [REG_W-1:0] MIN_MAX   = 8'd59;
    localparam logic [REG_W-1:0] HOUR_MAX  = 8'd23;
    localparam logic [REG_W-1:0] WDAY_MAX  = 8'd6;
    localparam logic [REG_W-1:0] MON_MAX   = 8'd12;
    localparam logic [REG_W-1:0] YEAR_MAX  = 8'd99;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_DAY  = 3'd3,
        SEL_WDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6
    } cal_sel_e;

    typedef enum logic [1:0] {
        GT_LIVE = 2'd0,
        GT_HOLD = 2'd1,
        GT_OWED = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic [REG_W-1:0] nxt;
        logic             carry;
    } bcd_step_t;

    function automatic logic [REG_W-1:0] bcd2bin(input logic [REG_W-1:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [REG_W-1:0] bin2bcd(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] t;
        logic [REG_W-1:0] u;
        t = v / 8'd10;
        u = v % 8'd10;
        return {t[3:0], u[3:0]};
    endfunction

    // Increment with wrap: any value at or beyond hi returns to lo.
    function automatic bcd_step_t bcd_step(input logic [REG_W-1:0] cur,
                                           input logic [REG_W-1:0] lo,
                                           input logic [REG_W-1:0] hi);
        bcd_step_t        r;
        logic [REG_W-1:0] b;
        b = bcd2bin(cur);
        if (b >= hi) begin
            r.nxt   = bin2bcd(lo);
            r.carry = 1'b1;
        end else begin
            r.nxt   = bin2bcd(b + 8'd1);
            r.carry = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] month_len(input logic [REG_W-1:0] mon_bcd,
                                                   input logic [REG_W-1:0] yr_bcd);
        logic [REG_W-1:0] m;
        logic [REG_W-1:0] y;
        m = bcd2bin(mon_bcd);
        y = bcd2bin(yr_bcd);
        unique case (m)
            8'd2:                      return (y[1:0] == 2'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = rtc_cal_pkg::PRESC_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic stop,
    output logic tick
);
    localparam int unsigned CW   = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] FIRE = CW'(DIV / 2 - 1);

    logic [CW-1:0] cnt_q;
    logic          tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= stb && !stop && (cnt_q == FIRE);
            if (stop)
                cnt_q <= '0;
            else if (stb)
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = tick_q;

    p_stop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (cnt_q == '0));

    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    input  logic wr_en,
    input  logic sec_wr,
    output logic advance
);
    gate_state_e state_q, state_d;
    logic        blocked;

    assign blocked = freeze | wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= GT_LIVE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            GT_LIVE, GT_HOLD: begin
                if (blocked)
                    state_d = (tick && !sec_wr) ? GT_OWED : GT_HOLD;
                else begin
                    state_d = GT_LIVE;
                    advance = tick;
                end
            end
            GT_OWED: begin
                if (sec_wr)
                    state_d = GT_HOLD;
                else if (blocked)
                    state_d = GT_OWED;
                else begin
                    advance = 1'b1;
                    state_d = tick ? GT_OWED : GT_LIVE;
                end
            end
            default: state_d = GT_LIVE;
        endcase
    end

    p_frozen_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !advance);

    p_sec_wr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> (state_q != GT_OWED));

endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             vlow,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] seconds_o,
    output logic [REG_W-1:0] minutes_o,
    output logic [REG_W-1:0] hours_o,
    output logic [REG_W-1:0] days_o,
    output logic [REG_W-1:0] weekday_o,
    output logic [REG_W-1:0] months_o,
    output logic [REG_W-1:0] years_o
);
    logic [REG_W-1:0] sec_q, min_q, hr_q, day_q, wd_q, mon_q, yr_q;
    logic             cen_q, vl_q;
    bcd_step_t        st_s, st_m, st_h, st_d, st_w, st_mo, st_y;
    logic             c_s, c_m, c_h, c_d, c_mo, c_y;
    logic             sec_wr;

    assign sec_wr = wr_en && (wr_sel == SEL_SEC);

    always_comb begin
        st_s  = bcd_step(sec_q, 8'd0, SEC_MAX);
        st_m  = bcd_step(min_q, 8'd0, MIN_MAX);
        st_h  = bcd_step(hr_q,  8'd0, HOUR_MAX);
        st_d  = bcd_step(day_q, 8'd1, month_len(mon_q, yr_q));
        st_w  = bcd_step(wd_q,  8'd0, WDAY_MAX);
        st_mo = bcd_step(mon_q, 8'd1, MON_MAX);
        st_y  = bcd_step(yr_q,  8'd0, YEAR_MAX);
        c_s   = st_s.carry;
        c_m   = c_s  & st_m.carry;
        c_h   = c_m  & st_h.carry;
        c_d   = c_h  & st_d.carry;
        c_mo  = c_d  & st_mo.carry;
        c_y   = c_mo & st_y.carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= 8'h00;
            min_q <= 8'h00;
            hr_q  <= 8'h00;
            day_q <= 8'h01;
            wd_q  <= 8'h00;
            mon_q <= 8'h01;
            yr_q  <= 8'h00;
            cen_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_SEC:  sec_q <= wr_data & 8'h7F;
                SEL_MIN:  min_q <= wr_data & 8'h7F;
                SEL_HOUR: hr_q  <= wr_data & 8'h3F;
                SEL_DAY:  day_q <= wr_data & 8'h3F;
                SEL_WDAY: wd_q  <= wr_data & 8'h07;
                SEL_MON: begin
                    mon_q <= wr_data & 8'h1F;
                    cen_q <= wr_data[7];
                end
                SEL_YEAR: yr_q  <= wr_data;
                default: ;
            endcase
        end else if (advance) begin
            sec_q <= st_s.nxt;
            if (c_s)  min_q <= st_m.nxt;
            if (c_m)  hr_q  <= st_h.nxt;
            if (c_h) begin
                day_q <= st_d.nxt;
                wd_q  <= st_w.nxt;
            end
            if (c_d)  mon_q <= st_mo.nxt;
            if (c_mo) yr_q  <= st_y.nxt;
            if (c_y)  cen_q <= ~cen_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vl_q <= 1'b1;
        else if (vlow)
            vl_q <= 1'b1;
        else if (sec_wr)
            vl_q <= wr_data[7];
    end

    assign seconds_o = sec_q | {vl_q, 7'd0};
    assign minutes_o = min_q;
    assign hours_o   = hr_q;
    assign days_o    = day_q;
    assign weekday_o = wd_q;
    assign months_o  = mon_q | {cen_q, 7'd0};
    assign years_o   = yr_q;

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_en && sec_q == 8'h59) |=> (sec_q == 8'h00));

    p_midnight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_en && sec_q == 8'h59 && min_q == 8'h59 && hr_q == 8'h23)
        |=> (hr_q == 8'h00));

    p_century_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_en && c_y) |=> (cen_q != $past(cen_q)));

    p_vl_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_q && !sec_wr) |=> vl_q);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned DIV = PRESC_DIV
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hz64_stb,
    input  logic       presc_stop,
    input  logic       freeze,
    input  logic       vlow,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] seconds_o,
    output logic [7:0] minutes_o,
    output logic [7:0] hours_o,
    output logic [7:0] days_o,
    output logic [7:0] weekday_o,
    output logic [7:0] months_o,
    output logic [7:0] years_o
);
    logic sec_tick;
    logic advance;
    logic sec_wr;

    assign sec_wr = wr_en && (wr_sel == SEL_SEC);

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (hz64_stb),
        .stop  (presc_stop),
        .tick  (sec_tick)
    );

    rtc_tick_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .freeze  (freeze),
        .wr_en   (wr_en),
        .sec_wr  (sec_wr),
        .advance (advance)
    );

    rtc_bcd_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .vlow      (vlow),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .seconds_o (seconds_o),
        .minutes_o (minutes_o),
        .hours_o   (hours_o),
        .days_o    (days_o),
        .weekday_o (weekday_o),
        .months_o  (months_o),
        .years_o   (years_o)
    );

endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hz64_stb = 1'b0;
    logic       presc_stop = 1'b0;
    logic       freeze = 1'b0;
    logic       vlow = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] seconds_o, minutes_o, hours_o, days_o, weekday_o, months_o, years_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model (binary fields)
    int ms, mm, mh, md, mwd, mmo, my, mcen, mvl, pc, owed;

    always #10 clk = ~clk;

    rtc_calendar_core u0 (
        .clk(clk), .rst_n(rst_n), .hz64_stb(hz64_stb), .presc_stop(presc_stop),
        .freeze(freeze), .vlow(vlow), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seconds_o(seconds_o), .minutes_o(minutes_o), .hours_o(hours_o), .days_o(days_o),
        .weekday_o(weekday_o), .months_o(months_o), .years_o(years_o)
    );

    function automatic logic [7:0] tobcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int frombcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void madv();
        if (ms >= 59) begin
            ms = 0;
            if (mm >= 59) begin
                mm = 0;
                if (mh >= 23) begin
                    mh = 0;
                    mwd = (mwd >= 6) ? 0 : mwd + 1;
                    if (md >= dim(mmo, my)) begin
                        md = 1;
                        if (mmo >= 12) begin
                            mmo = 1;
                            if (my >= 99) begin
                                my = 0;
                                mcen = 1 - mcen;
                            end else my = my + 1;
                        end else mmo = mmo + 1;
                    end else md = md + 1;
                end else mh = mh + 1;
            end else mm = mm + 1;
        end else ms = ms + 1;
    endfunction

    function automatic void mwrite(input int sel, input logic [7:0] d);
        case (sel)
            0: begin ms = frombcd(d & 8'h7F); mvl = (vlow || d[7]) ? 1 : 0; owed = 0; end
            1: mm = frombcd(d & 8'h7F);
            2: mh = frombcd(d & 8'h3F);
            3: md = frombcd(d & 8'h3F);
            4: mwd = int'(d[2:0]);
            5: begin mmo = frombcd(d & 8'h1F); mcen = int'(d[7]); end
            6: my = frombcd(d);
            default: ;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "seconds", seconds_o, tobcd(ms) | (mvl != 0 ? 8'h80 : 8'h00));
        chk(req, "minutes", minutes_o, tobcd(mm));
        chk(req, "hours",   hours_o,   tobcd(mh));
        chk(req, "days",    days_o,    tobcd(md));
        chk(req, "weekday", weekday_o, 8'(mwd));
        chk(req, "months",  months_o,  tobcd(mmo) | (mcen != 0 ? 8'h80 : 8'h00));
        chk(req, "years",   years_o,   tobcd(my));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) hz64_stb = 1'b1;
            @(negedge clk) hz64_stb = 1'b0;
            if (!presc_stop) begin
                pc = (pc + 1) % 64;
                if (pc == 32) begin
                    if (freeze) owed = 1;
                    else madv();
                end
            end
        end
    endtask

    task automatic to_tick();
        int n;
        n = (32 - pc + 64) % 64;
        if (n == 0) n = 64;
        strobe(n);
    endtask

    task automatic wr(input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mwrite(sel, d);
    endtask

    task automatic set_all(input int s, input int m, input int h, input int d,
                           input int wd, input int mo, input int y, input int cen);
        wr(6, tobcd(y));
        wr(5, tobcd(mo) | (cen != 0 ? 8'h80 : 8'h00));
        wr(4, 8'(wd));
        wr(3, tobcd(d));
        wr(2, tobcd(h));
        wr(1, tobcd(m));
        wr(0, tobcd(s));
        settle();
    endtask

    task automatic release_freeze(input string req);
        @(negedge clk) freeze = 1'b0;
        if (owed != 0) madv();
        owed = 0;
        @(negedge clk);
        chk_all(req);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        ms = 0; mm = 0; mh = 0; md = 1; mwd = 0; mmo = 1; my = 0; mcen = 0; mvl = 1;
        pc = 0; owed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R10 reset");

        // R2: stop then first tick at 32 strobes
        @(negedge clk) presc_stop = 1'b1;
        strobe(5);
        @(negedge clk) presc_stop = 1'b0;
        pc = 0;
        strobe(31); settle();
        chk("R2", "no tick before 32", seconds_o, 8'h80);
        strobe(1); settle();
        chk("R2", "first tick at 32", seconds_o, 8'h81);
        // R1: next tick after 64
        strobe(63); settle();
        chk("R1", "no tick at 63", seconds_o, 8'h81);
        strobe(1); settle();
        chk("R1", "tick at 64", seconds_o, 8'h82);

        // R10: clear the flag, set via vlow, clear blocked while vlow high
        wr(0, 8'h10); settle();
        chk("R10", "flag cleared", seconds_o, 8'h10);
        @(negedge clk) vlow = 1'b1;
        @(negedge clk) vlow = 1'b1;
        wr(0, 8'h11);
        @(negedge clk) vlow = 1'b0;
        settle();
        chk("R10", "flag held by vlow", seconds_o, 8'h91);
        wr(0, 8'h12); settle();
        chk("R10", "flag cleared again", seconds_o, 8'h12);

        // R3/R4: midnight, weekday wrap 6->0
        set_all(59, 59, 23, 15, 6, 7, 21, 0);
        to_tick(); settle();
        chk_all("R4 midnight");
        chk("R4", "weekday wrap", weekday_o, 8'h00);
        set_all(59, 14, 9, 3, 2, 3, 45, 0);
        to_tick(); settle();
        chk("R3", "minute carry", minutes_o, 8'h15);
        chk("R3", "seconds wrap", seconds_o, 8'h00);

        // R5: month lengths
        set_all(59, 59, 23, 30, 1, 4, 30, 0);
        to_tick(); settle();
        chk_all("R5 april end");
        set_all(59, 59, 23, 30, 1, 1, 30, 0);
        to_tick(); settle();
        chk("R5", "jan 31 exists", days_o, 8'h31);

        // R6: leap years
        set_all(59, 59, 23, 28, 1, 2, 24, 0);
        to_tick(); settle();
        chk("R6", "feb 29 in 24", days_o, 8'h29);
        to_tick(); settle();
        chk("R6", "still feb 29", days_o, 8'h29);
        set_all(59, 59, 23, 29, 1, 2, 24, 0);
        to_tick(); settle();
        chk_all("R6 mar 1 after 29");
        set_all(59, 59, 23, 28, 1, 2, 0, 0);
        to_tick(); settle();
        chk("R6", "feb 29 in 00", days_o, 8'h29);
        set_all(59, 59, 23, 28, 1, 2, 23, 0);
        to_tick(); settle();
        chk("R6", "mar 1 in 23", months_o, 8'h03);

        // R7: year and century
        set_all(59, 59, 23, 31, 5, 12, 99, 0);
        to_tick(); settle();
        chk_all("R7 century");
        chk("R7", "century bit", months_o, 8'h81);

        // R8: freeze with three ticks, one applied on release
        set_all(10, 20, 5, 10, 3, 6, 50, 0);
        @(negedge clk) freeze = 1'b1;
        to_tick(); strobe(128); settle();
        chk("R8", "frozen seconds", seconds_o, 8'h10);
        release_freeze("R8 release");
        chk("R8", "one tick applied", seconds_o, 8'h11);

        // R9: seconds write discards parked tick
        @(negedge clk) freeze = 1'b1;
        to_tick();
        wr(0, 8'h40);
        release_freeze("R9 sec write discard");
        settle();
        chk("R9", "no parked advance", seconds_o, 8'h40);

        // R9: write coinciding with tick is deferred
        strobe((31 - pc + 64) % 64);
        @(negedge clk) hz64_stb = 1'b1;
        @(negedge clk) hz64_stb = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33;
        @(negedge clk) wr_en = 1'b0;
        pc = 32; mwrite(1, 8'h33); madv();
        settle();
        chk_all("R9 deferred tick");
        // R9: seconds write coinciding with tick drops it
        strobe(63);
        @(negedge clk) hz64_stb = 1'b1;
        @(negedge clk) hz64_stb = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h05;
        @(negedge clk) wr_en = 1'b0;
        pc = 32; mwrite(0, 8'h05);
        settle();
        chk_all("R9 dropped tick");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int kind;
            kind = int'($urandom_range(0, 3));
            if (kind == 0) begin
                int sel;
                int v;
                sel = int'($urandom_range(0, 6));
                case (sel)
                    0, 1: v = int'($urandom_range(0, 59));
                    2: v = int'($urandom_range(0, 23));
                    3: v = int'($urandom_range(1, 28));
                    4: v = int'($urandom_range(0, 6));
                    5: v = int'($urandom_range(1, 12));
                    default: v = int'($urandom_range(0, 99));
                endcase
                wr(sel, (sel == 4) ? 8'(v) : tobcd(v));
                settle();
                chk_all("R9 random write");
            end else if (kind == 1) begin
                @(negedge clk) freeze = 1'b1;
                strobe(int'($urandom_range(1, 140)));
                settle();
                release_freeze("R8 random freeze");
            end else begin
                strobe(int'($urandom_range(1, 150)));
                settle();
                chk_all("R3 random run");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule